// File: doc/BRIEF.md
# Serial SAR Converter Output Sequencer

This block models the device side of a three-wire serial link on a successive-approximation converter. A 12-bit two's-complement word at a parallel input stands in for the analog core's result. An active-low chip select and a slow serial clock come from the host. The block runs entirely on a fast system clock that oversamples both of those inputs.

A falling chip select starts a conversion and captures the word. The first serial clock periods form the acquisition window, and during them the data line is released. After the second falling serial clock edge the block drives a single low null bit. It then shifts the word out most significant bit first. Without resending bit 0, it sends a mirrored copy from bit 1 up to bit 11, and then releases the line for the rest of the frame. Raising chip select aborts the frame at any point. A two-bit power status shows whether the converter is active, idle after completion, or fully powered down.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset, `sdo_oe` is 0, `sdo` is 0 and `pwr_state` is 2 (full power-down).
- R2: The word on `sample_in` is captured when the synchronized chip select falls. Later changes on `sample_in` have no effect on the bits sent in that frame.
- R3: `sdo_oe` stays 0 after the first falling `sclk` edge of a frame. After the second falling edge, `sdo_oe` is 1 and `sdo` is 0 (the null bit) for one serial period.
- R4: Falling edges 3 to 14 put result bits 11 down to 0 on `sdo`, one bit per serial period.
- R5: Falling edges 15 to 25 put result bits 1 up to 11 on `sdo`. Bit 0 is not sent again.
- R6: Falling edge 26 sets `sdo_oe` to 0. Any further serial clocks leave `sdo_oe` at 0.
- R7: `sdo` and `sdo_oe` change only in response to a synchronized `sclk` fall or a chip select change. Each change appears three system clocks after the input edge.
- R8: Raising `cs_n` at any point sets `sdo_oe` to 0 and `pwr_state` to 2 within three system clocks.
- R9: A new frame starts only when `cs_n` goes high and then low. Holding `cs_n` low after a frame completes never restarts output.
- R10: `pwr_state` is 0 from the start of a frame until it completes, 1 while `cs_n` stays low after completion, and 2 while `cs_n` is high.
- R11: Words are sent unchanged as two's complement. 0x800 (negative full scale) goes out as a 1 followed by eleven 0s, and 0x7FF (positive full scale) goes out as a 0 followed by eleven 1s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock from the host |
| cs_n_in | input | 1 | Active-low chip select from the host |
| sample_in | input | 12 | Two's-complement result word to send |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Drive enable for the data line (0 means released) |
| pwr_state | output | 2 | 0 active, 1 converted-idle, 2 full power-down |

## Verification
The bench targets the seam between the two halves of a frame. A design that resent bit 0 would shift every mirrored bit by one period, and a design that stopped one edge early would leave bit 11 unrepeated. It checks the release of the line during the first acquisition edge, which an off-by-one acquisition count would drive with data. It aborts a frame midway and then keeps clocking with chip select held low after completion. These steps catch a design that keeps driving after an abort, or that restarts without a fresh chip select fall. It changes `sample_in` mid-frame to expose a design that shifts the live input instead of the captured word.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PWR_ACTIVE    = 2'd0,
    PWR_CONV_IDLE = 2'd1,
    PWR_FULL_DOWN = 2'd2
  } pwr_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ACQ,
    SQ_SHIFT,
    SQ_DONE
  } seq_e;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= RESET_VAL;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fall  = prev & ~chain[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall); // R7

endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH     = 12,
  parameter int ACQ_FALLS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_high,
  input  logic             cs_fall,
  input  logic             sclk_fall,
  input  logic [WIDTH-1:0] sample,
  output logic             sdo,
  output logic             sdo_oe,
  output pwr_e             pwr
);

  localparam int FRAME_LEN = 2 * WIDTH;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int IDX_W     = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  seq_e             state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] sel_wide;
  logic [IDX_W-1:0] bit_idx;
  logic [WIDTH-1:0] word;

  always_comb begin
    nxt = cnt + 1'b1;
    if (nxt <= CNT_W'(WIDTH)) sel_wide = CNT_W'(WIDTH) - nxt;
    else                      sel_wide = nxt - CNT_W'(WIDTH);
    bit_idx = IDX_W'(sel_wide);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
      word   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      pwr    <= PWR_FULL_DOWN;
    end else if (cs_high) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      pwr    <= PWR_FULL_DOWN;
    end else if (cs_fall) begin
      state  <= SQ_ACQ;
      cnt    <= '0;
      word   <= sample;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      pwr    <= PWR_ACTIVE;
    end else if (sclk_fall) begin
      case (state)
        SQ_ACQ: begin
          if (nxt == CNT_W'(ACQ_FALLS)) begin
            state  <= SQ_SHIFT;
            cnt    <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b1;
          end else begin
            cnt <= nxt;
          end
        end
        SQ_SHIFT: begin
          if (nxt == CNT_W'(FRAME_LEN)) begin
            state  <= SQ_DONE;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
            pwr    <= PWR_CONV_IDLE;
          end else begin
            cnt <= nxt;
            sdo <= word[bit_idx];
          end
        end
        default: ;
      endcase
    end
  end

  AST_CS_HIGH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_high |=> (!sdo_oe && pwr == PWR_FULL_DOWN)); // R8
  AST_NULL_LEADS: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> !sdo); // R3
  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!sclk_fall && !cs_high && !cs_fall) |=> ($stable(sdo) && $stable(sdo_oe))); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (pwr == PWR_CONV_IDLE) |-> !sdo_oe); // R6
  AST_NO_SELF_START: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_DONE && !cs_fall) |=> (state != SQ_ACQ)); // R9

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int ACQ_FALLS   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_in,
  input  logic             cs_n_in,
  input  logic [WIDTH-1:0] sample_in,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [1:0]       pwr_state
);

  logic cs_level, cs_fall, sclk_level, sclk_fall;
  pwr_e pwr;

  edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .din(cs_n_in), .level(cs_level), .fall(cs_fall)
  );

  edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst(rst), .din(sclk_in), .level(sclk_level), .fall(sclk_fall)
  );

  sar_frame_ctrl #(.WIDTH(WIDTH), .ACQ_FALLS(ACQ_FALLS)) u_ctrl (
    .clk(clk), .rst(rst), .cs_high(cs_level), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall & ~cs_level), .sample(sample_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .pwr(pwr)
  );

  assign pwr_state = pwr;

  AST_FULLDOWN_TRACKS_CS: assert property (@(posedge clk) disable iff (rst)
    (cs_level && sclk_level) |=> (pwr_state == 2'd2)); // R10

endmodule

// File: tb/sar_serial_seq_test.sv
module sar_serial_seq_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        sclk_in;
  logic        cs_n_in;
  logic [11:0] sample_in;
  logic        sdo;
  logic        sdo_oe;
  logic [1:0]  pwr_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sar_serial_seq uut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .cs_n_in(cs_n_in),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .pwr_state(pwr_state)
  );

  // R11: full-scale codes included
  localparam logic [11:0] VEC [6] = '{12'h800, 12'h7FF, 12'hA5C, 12'h001, 12'h000, 12'h3C6};

  task automatic check(input logic [11:0] act, input logic [11:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half(); repeat (8) @(negedge clk); endtask

  // falling edge, settle, (caller checks), then rising edge
  task automatic sclk_down(); sclk_in = 1'b0; half(); endtask
  task automatic sclk_up();   sclk_in = 1'b1; half(); endtask

  task automatic start_frame(input logic [11:0] w);
    sample_in = w;
    cs_n_in = 1'b0;
    half();
    check({11'd0, sdo_oe}, 12'd0, "R3 released at start");
    check({10'd0, pwr_state}, 12'd0, "R10 active");
    sclk_down();
    check({11'd0, sdo_oe}, 12'd0, "R3 released after first fall");
    sclk_up();
    sclk_down();
    check({10'd0, sdo_oe, sdo}, 12'd2, "R3 null bit driven low");
    sclk_up();
  endtask

  task automatic run_frame(input logic [11:0] w, input logic [11:0] poke);
    start_frame(w);
    sample_in = poke;
    for (int k = 1; k <= 23; k++) begin
      int b;
      b = (k <= 12) ? 12 - k : k - 12;
      sclk_down();
      if (k <= 12) check({10'd0, sdo_oe, sdo}, {10'd0, 1'b1, w[b]}, "R4 R11 msb-first bit");
      else         check({10'd0, sdo_oe, sdo}, {10'd0, 1'b1, w[b]}, "R5 mirrored bit");
      sclk_up();
    end
    sclk_down();
    check({11'd0, sdo_oe}, 12'd0, "R6 released after repeat");
    check({10'd0, pwr_state}, 12'd1, "R10 converted idle");
    sclk_up();
    for (int k = 0; k < 3; k++) begin
      sclk_down();
      check({11'd0, sdo_oe}, 12'd0, "R6 R9 extra clocks ignored");
      sclk_up();
    end
    check({10'd0, pwr_state}, 12'd1, "R9 still idle with cs low");
    cs_n_in = 1'b1;
    half();
    check({10'd0, pwr_state}, 12'd2, "R10 full power-down");
  endtask

  initial begin
    rst = 1'b1; sclk_in = 1'b1; cs_n_in = 1'b1; sample_in = 12'h000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({10'd0, sdo_oe, sdo}, 12'd0, "R1 outputs after reset");
    check({10'd0, pwr_state}, 12'd2, "R1 power after reset");

    foreach (VEC[i]) run_frame(VEC[i], VEC[i]);

    // R2: input changed right after capture
    run_frame(12'h9B3, 12'h64C);

    // R8: abort midway through the msb-first part
    start_frame(12'hFFF);
    for (int k = 0; k < 4; k++) begin sclk_down(); sclk_up(); end
    sclk_down();
    cs_n_in = 1'b1;
    repeat (4) @(negedge clk);
    check({11'd0, sdo_oe}, 12'd0, "R8 abort releases line");
    check({10'd0, pwr_state}, 12'd2, "R8 abort powers down");
    sclk_up();
    for (int k = 0; k < 3; k++) begin
      sclk_down();
      check({11'd0, sdo_oe}, 12'd0, "R9 no start while cs high");
      sclk_up();
    end

    // R7: output waits for the synchronizer delay after a fall
    sample_in = 12'h800;
    cs_n_in = 1'b0;
    half();
    sclk_down(); sclk_up();
    sclk_in = 1'b0;
    repeat (2) @(negedge clk);
    check({11'd0, sdo_oe}, 12'd0, "R7 no change before sync delay");
    @(negedge clk);
    check({10'd0, sdo_oe, sdo}, 12'd2, "R7 change after three clocks");
    half();
    sclk_up();
    sclk_down();
    check({10'd0, sdo_oe, sdo}, 12'd3, "R11 sign bit of 0x800");
    sclk_up();
    cs_n_in = 1'b1;
    half();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule